// File: doc/BRIEF.md
# Four-Channel Time-Shared FIR Filter

This block filters four independent sample streams with 150-tap FIR responses while owning only one multiplier and one accumulator. Each pulse on the sample strobe opens a frame. The controller writes the four new input words into per-channel circular history memories. It then steps a single multiply-accumulate engine through all 150 taps of channel 0, then channel 1, and so on, and publishes the four filtered words together with a one-cycle valid pulse. One frame takes 602 clocks. At a 10 MHz clock and a 1 kHz strobe this leaves most of the 10,000-clock period idle.

Coefficients come from one shared coefficient memory that is loaded through a simple write port. History entries are never moved. Only the newest-entry pointer advances, so tap k always meets the sample k strobes old. After reset the block spends NTAPS clocks zeroing the history before it accepts a strobe. A strobe that arrives while the block is busy is dropped and reported as an overrun.

Top module: `fir_tdm_top`

## Requirements
- R1: While reset is held and after it is released, `valid_o` and `overrun_o` are 0 and `res_o` is all zeros. The history reads as zero after the post-reset clear, so the first frame's outputs depend only on the first sample.
- R2: A cycle with `coef_we_i`=1 stores `coef_data_i`, read as a signed 16-bit value, as coefficient `coef_addr_i` (0..NTAPS-1). A frame started after the write uses the new value.
- R3: For each channel c, the result is y = sum over k=0..NTAPS-1 of coef[k]·x_c[n-k]. Inputs and coefficients are signed 16-bit, and x_c[n] is the newest sample. The sum is accumulated exactly in 40 signed bits, and `res_o` carries accumulator bits [30:15].
- R4: The history is circular with depth NTAPS. A sample contributes for exactly NTAPS frames (taps 0..NTAPS-1) and then drops out.
- R5: Channel c uses bits [16c+15:16c] of `samp_i` and drives bits [16c+15:16c] of `res_o`. Channels do not affect one another.
- R6: `valid_o` is a single-cycle pulse. It rises exactly NCH·NTAPS+2 clocks after the clock edge that accepts a strobe.
- R7: `res_o` changes only in the cycle in which `valid_o` is high, and it holds between pulses.
- R8: A strobe seen while a frame or the post-reset clear is running raises `overrun_o` for one cycle on the next clock. Its samples are not stored, and the running frame is not disturbed.
- R9: Full-scale inputs (-32768) combined with full-scale coefficients (-32768) on all taps still give exactly the R3 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_i | input | 1 | Sample-period strobe that starts a frame |
| samp_i | input | NCH*16 | New input sample per channel, channel c at bits [16c+15:16c] |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 8 | Coefficient index being written |
| coef_data_i | input | 16 | Signed coefficient value |
| res_o | output | NCH*16 | Filtered result per channel, same packing as samp_i |
| valid_o | output | 1 | One-cycle pulse when all results are updated |
| overrun_o | output | 1 | One-cycle pulse for a strobe dropped while busy |

## Verification
The first input pattern is a single impulse on each channel, with a different amplitude and sign per channel, followed by zero frames. This shows that tap k is paired with coefficient k, that the history starts cleared, and that the channels stay separate. A coefficient rewritten between frames separates a live coefficient read from a stale one. A strobe injected during a running frame, and another during the clear, must produce an overrun pulse and leave the later results exactly as if the strobe had never occurred. A run of more than 150 frames follows, with random samples on three channels and a constant full-scale value on the fourth, all against full-scale coefficients. It checks that old samples leave the window when the pointer wraps, and that the worst-case sum is computed exactly.

// File: rtl/fir_tdm_pkg.sv
package fir_tdm_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_IDLE  = 3'd1,
    ST_RUN   = 3'd2,
    ST_FLUSH = 3'd3,
    ST_PUB   = 3'd4
  } fir_state_e;
endpackage

// File: rtl/fir_tdm_hist.sv
// Per-channel circular sample history, one write port shared by all banks,
// registered read data.
module fir_tdm_hist #(
  parameter int NCH   = 4,
  parameter int DEPTH = 150,
  parameter int DW    = 16,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [NCH*DW-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [NCH*DW-1:0] rdata
);
  for (genvar c = 0; c < NCH; c++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && (waddr < AW'(DEPTH))) mem[waddr] <= wdata[c*DW +: DW];
      rd_q <= mem[raddr];
    end
    assign rdata[c*DW +: DW] = rd_q;
  end
endmodule

// File: rtl/fir_tdm_coef.sv
// Coefficient store: write port for loading, registered read for the engine.
module fir_tdm_coef #(
  parameter int DEPTH = 150,
  parameter int CW    = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we && (waddr < AW'(DEPTH))) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_tdm_mac.sv
// Single multiply-accumulate engine; 'first' restarts the sum.
module fir_tdm_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 40,
  parameter int SH   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [DW-1:0] samp,
  input  logic [CW-1:0] coef,
  output logic [DW-1:0] out
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_sum;

  always_comb begin
    prod     = $signed(samp) * $signed(coef);
    prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
    acc_sum  = (first ? '0 : acc_q) + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_sum;
  end

  assign out = acc_sum[SH+DW-1:SH];
endmodule

// File: rtl/fir_tdm_top.sv
// Four-channel FIR sharing one MAC. rst_n must be synchronised to clk upstream.
module fir_tdm_top
  import fir_tdm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NTAPS = 150,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int ACCW  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [NCH*DW-1:0] samp_i,
  input  logic              coef_we_i,
  input  logic [7:0]        coef_addr_i,
  input  logic [CW-1:0]     coef_data_i,
  output logic [NCH*DW-1:0] res_o,
  output logic              valid_o,
  output logic              overrun_o
);
  localparam int AW  = $clog2(NTAPS);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SH  = CW - 1;

  fir_state_e state_q, state_d;
  logic [AW-1:0]  wptr_q, wptr_d, rptr_q, rptr_d, tap_q, tap_d, wnext;
  logic [CHW-1:0] ch_q, ch_d;
  logic           frame_start, issue, last_tap;
  logic           pv_q, pfirst_q, plast_q;
  logic [CHW-1:0] pch_q;
  logic           h_we;
  logic [AW-1:0]  h_waddr;
  logic [NCH*DW-1:0] h_wdata, h_rdata;
  logic [CW-1:0]  c_rdata;
  logic [DW-1:0]  mac_out;
  logic [DW-1:0]  res_int_q [NCH];
  logic [NCH*DW-1:0] res_pack;
  logic           valid_d, ovr_d;

  assign frame_start = (state_q == ST_IDLE) && strobe_i;
  assign issue       = (state_q == ST_RUN);
  assign last_tap    = (tap_q == AW'(NTAPS-1));
  assign wnext       = (wptr_q == AW'(NTAPS-1)) ? '0 : wptr_q + AW'(1);

  // next-state logic
  always_comb begin
    state_d = state_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    tap_d   = tap_q;
    ch_d    = ch_q;
    unique case (state_q)
      ST_CLEAR: begin
        if (last_tap) begin
          tap_d   = '0;
          state_d = ST_IDLE;
        end else begin
          tap_d = tap_q + AW'(1);
        end
      end
      ST_IDLE: begin
        if (strobe_i) begin
          wptr_d  = wnext;
          rptr_d  = wnext;
          tap_d   = '0;
          ch_d    = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (last_tap) begin
          tap_d  = '0;
          rptr_d = wptr_q;
          if (ch_q == CHW'(NCH-1)) state_d = ST_FLUSH;
          else                     ch_d    = ch_q + CHW'(1);
        end else begin
          tap_d  = tap_q + AW'(1);
          rptr_d = (rptr_q == '0) ? AW'(NTAPS-1) : rptr_q - AW'(1);
        end
      end
      ST_FLUSH: state_d = ST_PUB;
      ST_PUB:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    valid_d = (state_q == ST_PUB);
    ovr_d   = strobe_i && (state_q != ST_IDLE);
  end

  // history write port: zero fill during clear, new samples on frame start
  always_comb begin
    h_we    = (state_q == ST_CLEAR) || frame_start;
    h_waddr = (state_q == ST_CLEAR) ? tap_q : wnext;
    h_wdata = (state_q == ST_CLEAR) ? '0 : samp_i;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_CLEAR;
      wptr_q    <= '0;
      rptr_q    <= '0;
      tap_q     <= '0;
      ch_q      <= '0;
      pv_q      <= 1'b0;
      pfirst_q  <= 1'b0;
      plast_q   <= 1'b0;
      pch_q     <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_d;
      tap_q     <= tap_d;
      ch_q      <= ch_d;
      pv_q      <= issue;
      pfirst_q  <= issue && (tap_q == '0);
      plast_q   <= issue && last_tap;
      pch_q     <= ch_q;
      valid_o   <= valid_d;
      overrun_o <= ovr_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  res_int_q[c] <= '0;
      else if (pv_q && plast_q && (pch_q == CHW'(c))) res_int_q[c] <= mac_out;
    end
    assign res_pack[c*DW +: DW] = res_int_q[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_o <= '0;
    else if (valid_d) res_o <= res_pack;
  end

  fir_tdm_hist #(.NCH(NCH), .DEPTH(NTAPS), .DW(DW), .AW(AW)) i_hist (
    .clk(clk), .we(h_we), .waddr(h_waddr), .wdata(h_wdata),
    .raddr(rptr_q), .rdata(h_rdata)
  );

  fir_tdm_coef #(.DEPTH(NTAPS), .CW(CW), .AW(AW)) i_coef (
    .clk(clk), .we(coef_we_i), .waddr(coef_addr_i[AW-1:0]), .wdata(coef_data_i),
    .raddr(tap_q), .rdata(c_rdata)
  );

  fir_tdm_mac #(.DW(DW), .CW(CW), .ACCW(ACCW), .SH(SH)) i_mac (
    .clk(clk), .rst_n(rst_n), .en(pv_q), .first(pfirst_q),
    .samp(h_rdata[int'(pch_q)*DW +: DW]), .coef(c_rdata), .out(mac_out)
  );
endmodule

// File: rtl/fir_tdm_chk.sv
module fir_tdm_chk #(
  parameter int NCH   = 4,
  parameter int NTAPS = 150,
  parameter int DW    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     strobe_i,
  input logic                     frame_start,
  input logic                     valid_o,
  input logic                     overrun_o,
  input logic [NCH*DW-1:0]        res_o,
  input logic [$clog2(NTAPS)-1:0] wptr_i
);
  localparam int LAT = NCH*NTAPS + 3;

  logic [15:0] cnt_q;
  logic        act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (frame_start) begin
      cnt_q <= 16'd1;
      act_q <= 1'b1;
    end else if (valid_o) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 16'd1;
    end
  end

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (act_q && cnt_q == 16'(LAT)));
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_res_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_o) |-> valid_o);
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(strobe_i));
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!act_q || valid_o));
  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_i < $clog2(NTAPS)'(NTAPS));
endmodule

bind fir_tdm_top fir_tdm_chk #(.NCH(NCH), .NTAPS(NTAPS), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .frame_start(frame_start),
  .valid_o(valid_o), .overrun_o(overrun_o), .res_o(res_o), .wptr_i(wptr_q)
);

// File: tb/test_fir_tdm_top.sv
module test_fir_tdm_top;
  localparam int NCH = 4;
  localparam int NT  = 150;
  localparam int DW  = 16;
  localparam int LAT = NCH*NT + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              strobe_i;
  logic [NCH*DW-1:0] samp_i;
  logic              coef_we_i;
  logic [7:0]        coef_addr_i;
  logic [15:0]       coef_data_i;
  logic [NCH*DW-1:0] res_o;
  logic              valid_o;
  logic              overrun_o;

  int checks = 0;
  int errors = 0;
  int coef_m [NT];
  int hist_m [NCH][NT];
  int wp_m = 0;
  int nxt [NCH];
  string cur_req = "R3";
  logic [NCH*DW-1:0] exp_q [$];
  logic [NCH*DW-1:0] prev_pub = '0;
  bit done = 0;

  always #5 clk = ~clk;

  fir_tdm_top i_fir_tdm_top (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .samp_i(samp_i),
    .coef_we_i(coef_we_i), .coef_addr_i(coef_addr_i), .coef_data_i(coef_data_i),
    .res_o(res_o), .valid_o(valid_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic load_coef(input int k, input int v);
    @(negedge clk);
    coef_we_i = 1'b1; coef_addr_i = 8'(k); coef_data_i = 16'(v);
    @(negedge clk);
    coef_we_i = 1'b0;
    coef_m[k] = v;
  endtask

  // driver: update model, push expectation, strobe, time the valid pulse
  task automatic run_frame(input bit poke);
    logic [NCH*DW-1:0] e;
    int lat;
    wp_m = (wp_m + 1) % NT;
    for (int c = 0; c < NCH; c++) begin
      longint s = 0;
      logic [63:0] u;
      hist_m[c][wp_m] = nxt[c];
      for (int k = 0; k < NT; k++)
        s += longint'(coef_m[k]) * longint'(hist_m[c][(wp_m - k + NT) % NT]);
      u = 64'(s);
      e[c*DW +: DW] = u[30:15];
    end
    exp_q.push_back(e);
    @(negedge clk);
    strobe_i = 1'b1;
    for (int c = 0; c < NCH; c++) samp_i[c*DW +: DW] = 16'(nxt[c]);
    @(posedge clk);
    @(negedge clk);
    strobe_i = 1'b0;
    lat = 0;
    while (!valid_o && lat < LAT + 20) begin
      if (lat == 300) chk(res_o == prev_pub, "R7", longint'(res_o[15:0]), longint'(prev_pub[15:0]));
      if (poke && lat == 100) begin
        strobe_i = 1'b1;
        samp_i   = {NCH{16'h5a5a}};
      end
      if (poke && lat == 101) begin
        strobe_i = 1'b0;
        chk(overrun_o == 1'b1, "R8", longint'(overrun_o), 1);
      end
      @(negedge clk);
      lat++;
    end
    chk(lat == LAT, "R6", lat, LAT);
    @(negedge clk);
    chk(valid_o == 1'b0, "R6", longint'(valid_o), 0);
    prev_pub = e;
  endtask

  // monitor: compare published results against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && valid_o === 1'b1 && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", 1, 0);
      end else begin
        logic [NCH*DW-1:0] e;
        e = exp_q.pop_front();
        for (int c = 0; c < NCH; c++)
          chk(res_o[c*DW +: DW] == e[c*DW +: DW], cur_req,
              longint'($signed(res_o[c*DW +: DW])), longint'($signed(e[c*DW +: DW])));
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_i = 1'b0; samp_i = '0;
    coef_we_i = 1'b0; coef_addr_i = '0; coef_data_i = '0;
    for (int c = 0; c < NCH; c++) for (int k = 0; k < NT; k++) hist_m[c][k] = 0;
    repeat (3) @(negedge clk);
    chk(valid_o == 0 && overrun_o == 0 && res_o == '0, "R1", longint'(res_o[15:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 0 && overrun_o == 0 && res_o == '0, "R1", longint'(valid_o), 0);
    // strobe during the clear: dropped and flagged
    repeat (3) @(negedge clk);
    strobe_i = 1'b1; samp_i = {NCH{16'h7777}};
    @(negedge clk);
    strobe_i = 1'b0;
    chk(overrun_o == 1'b1, "R8", longint'(overrun_o), 1);
    @(negedge clk);
    chk(overrun_o == 1'b0, "R8", longint'(overrun_o), 0);
    repeat (NT + 10) @(negedge clk);

    // ramp coefficients so every tap is distinguishable
    for (int k = 0; k < NT; k++) load_coef(k, k*100 - 7000);

    // impulse: first frame sees only the new sample (cleared history)
    cur_req = "R1";
    nxt = '{16384, -16384, 32767, 8192};
    run_frame(0);
    cur_req = "R5";
    nxt = '{0, 0, 0, 0};
    run_frame(0);
    cur_req = "R4";
    run_frame(0);
    // rewrite coefficient 3: the impulse is now three frames back
    load_coef(3, 12345);
    cur_req = "R2";
    run_frame(0);
    // strobe injected during a frame must change nothing
    cur_req = "R8";
    nxt = '{1000, -2000, 3000, -4000};
    run_frame(1);
    nxt = '{-5, 7, -9, 11};
    run_frame(0);

    // full-scale coefficients; long run wraps the history
    for (int k = 0; k < NT; k++) load_coef(k, -32768);
    for (int f = 0; f < NT + 5; f++) begin
      cur_req = (f >= NT - 1) ? "R9" : "R4";
      nxt[0] = -32768;
      for (int c = 1; c < NCH; c++) nxt[c] = int'($urandom_range(0, 65535)) - 32768;
      run_frame(0);
    end
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule